// File: doc/BRIEF.md
# Event Readout Handshake Sequencer

This block moves the data words of one event from a trigger module into a local FIFO, then tells the trigger module that the event is finished. A rising edge on the start-readout input opens an event. The sequencer pulses a readout-enable request, and the trigger module then offers words one at a time on a data-ready line. Each accepted word is acknowledged and written into the FIFO. A last-pass line from the trigger module marks the end of the internal transfer.

A completion-mode bit chooses when the active-low end-of-event reset goes out. In early mode it is issued as soon as last-pass arrives. In late mode the block waits for a pulse from the external readout that drains the FIFO. A bypass bit takes the card out of readout altogether. A test-mode bit lets two software strobes stand in for the trigger module: one produces a readout-enable pulse and the other produces a last-pass.

A separate watchdog checks that the trigger module answers each validation with a valack. It counts one tick per clock; with a 16 MHz clock a tick is 62.5 ns, so a limit of 1600 gives 100 us. If no valack arrives before the limit, the watchdog raises a timeout flag.

Top module: `evt_readout_seq`

## Requirements
- R1: After reset, `renin` is 0, `word_ack` is 0, `fifo_we` is 0, `tmo_flag` is 0 and `eoe_n` is 1.
- R2: When the block is idle and `cfg_bypass` is 0, a low-to-high change of `start_rd` drives `renin` to 1 for exactly the one cycle after the edge where the change is sampled. Holding `start_rd` high does not produce another pulse.
- R3: While an event transfer is open, `dready` at 1 on an edge where `word_ack` is 0 drives `word_ack` and `fifo_we` to 1 for one cycle after that edge, with `fifo_wdata` equal to the `din` sampled there. If `dready` stays high through the acknowledge cycle, no second word is taken.
- R4: `dready` is ignored when no transfer is open, including while the block waits for external completion. No acknowledge and no FIFO write follow.
- R5: With `cfg_early_done` = 1, a last-pass closes the transfer and drives `eoe_n` to 0 in the cycle after that edge. The block then returns to idle.
- R6: With `cfg_early_done` = 0, a last-pass leaves `eoe_n` at 1. A later `ext_done` pulse drives `eoe_n` to 0 in the cycle after it is sampled. An `ext_done` pulse while idle has no effect.
- R7: Whenever `eoe_n` goes to 0, it stays there for exactly one cycle.
- R8: While `cfg_bypass` is 1, a rising edge on `start_rd` produces no `renin` and opens no transfer. A following `dready` gets no acknowledge.
- R9: With `cfg_tmo_en` = 1, a cycle with `val_in` = 1 arms the watchdog. If `valack_in` stays low, `tmo_flag` rises exactly `tmo_limit` cycles after the arming edge, provided `tmo_limit` is at least 1. The flag stays up until the next arming or until the enable is cleared.
- R10: A `valack_in` that arrives before the limit disarms the watchdog, and no flag follows. With `cfg_tmo_en` = 0 the flag stays 0, and clearing the enable drops a raised flag on the next cycle.
- R11: With `cfg_test_mode` = 1, `tst_rd_strobe` drives `renin` to 1 in the next cycle, and `tst_wr_strobe` acts as a last-pass. With `cfg_test_mode` = 0 both strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one watchdog tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_test_mode | input | 1 | 1 = software strobes replace the trigger module's readout signals |
| cfg_tmo_en | input | 1 | 1 = valack watchdog active |
| cfg_bypass | input | 1 | 1 = card excluded from readout |
| cfg_early_done | input | 1 | 1 = end-of-event reset at last-pass; 0 = at external completion |
| tmo_limit | input | TMO_W | Watchdog limit in clock ticks |
| start_rd | input | 1 | Start-readout level; its rising edge opens an event |
| dready | input | 1 | Word offered by the trigger module, active high |
| din | input | DATA_W | Word data |
| last_pass | input | 1 | End of internal transfer, active high |
| ext_done | input | 1 | Single-cycle pulse: external readout finished |
| tst_rd_strobe | input | 1 | Test strobe that produces a readout-enable pulse |
| tst_wr_strobe | input | 1 | Test strobe that produces a last-pass |
| val_in | input | 1 | Validation; arms the watchdog |
| valack_in | input | 1 | Validation acknowledge; disarms the watchdog |
| renin | output | 1 | Readout-enable request pulse |
| word_ack | output | 1 | Per-word acknowledge, active high |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | DATA_W | Word written to the FIFO |
| eoe_n | output | 1 | End-of-event reset, active low |
| tmo_flag | output | 1 | 1 = valack timeout expired |

## Verification
The bench targets a start level that is held high. A level-sensitive design would pulse `renin` again and again there. It offers a word whose ready line stays up through its acknowledge cycle. A design without the acknowledge guard would then write that word to the FIFO twice. It raises `dready` while the block waits for external completion, and pulses `ext_done` while idle. These catch a sequencer that leaves its transfer state too late, or that issues a stray end-of-event reset. Watchdog runs with random limits sample the flag on the last quiet cycle and on the expiry cycle, so an off-by-one counter is caught. Valacks placed just before the limit catch a design that checks expiry before the acknowledge.

// File: rtl/evrd_pkg.sv
package evrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_XFER     = 2'd1,
        ST_WAIT_EXT = 2'd2,
        ST_EOE      = 2'd3
    } evrd_st_e;
endpackage

// File: rtl/evrd_rise.sv
module evrd_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/evrd_wdog.sv
module evrd_wdog #(
    parameter int TMO_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             val_i,
    input  logic             valack_i,
    output logic             flag_o
);
    typedef struct packed {
        logic             armed;
        logic             flag;
        logic [TMO_W-1:0] cnt;
    } wd_t;

    localparam wd_t WD_RST = '{armed: 1'b0, flag: 1'b0, cnt: '0};

    wd_t r_d, r_q;
    logic [TMO_W:0] ticks;

    always_comb begin
        r_d   = r_q;
        ticks = {1'b0, r_q.cnt} + 1'b1;
        if (!en_i) begin
            r_d = WD_RST;
        end else if (val_i) begin
            r_d.armed = 1'b1;
            r_d.flag  = 1'b0;
            r_d.cnt   = '0;
        end else if (r_q.armed) begin
            if (valack_i) begin
                r_d.armed = 1'b0;
            end else if (ticks >= {1'b0, limit_i}) begin
                r_d.armed = 1'b0;
                r_d.flag  = 1'b1;
            end else begin
                r_d.cnt = ticks[TMO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= WD_RST;
        else        r_q <= r_d;
    end

    assign flag_o = r_q.flag;

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flag |-> $past(en_i)) else $error("flag without enable"); // R10
    AST_ACK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.armed && valack_i && !val_i && en_i) |=> !r_q.flag) else $error("flag after valack"); // R10
    AST_FLAG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(r_q.armed)) else $error("flag while unarmed"); // R9
endmodule

// File: rtl/evrd_ctl.sv
module evrd_ctl
    import evrd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rise_i,
    input  logic              dready_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              lastpass_i,
    input  logic              ext_done_i,
    input  logic              tst_rd_i,
    input  logic              tst_wr_i,
    input  logic              cfg_test_i,
    input  logic              cfg_bypass_i,
    input  logic              cfg_early_i,
    output logic              renin_o,
    output logic              ack_o,
    output logic              we_o,
    output logic [DATA_W-1:0] data_o,
    output logic              eoe_n_o
);
    typedef struct packed {
        evrd_st_e          st;
        logic              renin;
        logic              ack;
        logic              we;
        logic              eoe_n;
        logic [DATA_W-1:0] data;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, renin: 1'b0, ack: 1'b0,
                                 we: 1'b0, eoe_n: 1'b1, data: '0};

    ctl_t r_d, r_q;
    logic lp_eff;

    always_comb begin
        r_d       = r_q;
        r_d.renin = cfg_test_i & tst_rd_i;
        r_d.ack   = 1'b0;
        r_d.we    = 1'b0;
        r_d.eoe_n = 1'b1;
        lp_eff    = lastpass_i | (cfg_test_i & tst_wr_i);
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_rise_i && !cfg_bypass_i) begin
                    r_d.st    = ST_XFER;
                    r_d.renin = 1'b1;
                end
            end
            ST_XFER: begin
                if (dready_i && !r_q.ack) begin
                    r_d.ack  = 1'b1;
                    r_d.we   = 1'b1;
                    r_d.data = din_i;
                end
                if (lp_eff) begin
                    if (cfg_early_i) begin
                        r_d.st    = ST_EOE;
                        r_d.eoe_n = 1'b0;
                    end else begin
                        r_d.st = ST_WAIT_EXT;
                    end
                end
            end
            ST_WAIT_EXT: begin
                if (ext_done_i) begin
                    r_d.st    = ST_EOE;
                    r_d.eoe_n = 1'b0;
                end
            end
            ST_EOE:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign renin_o = r_q.renin;
    assign ack_o   = r_q.ack;
    assign we_o    = r_q.we;
    assign data_o  = r_q.data;
    assign eoe_n_o = r_q.eoe_n;

    AST_EOE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eoe_n |=> r_q.eoe_n) else $error("eoe held low"); // R7
    AST_EOE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.eoe_n |-> $past(lastpass_i || tst_wr_i || ext_done_i)) else $error("eoe without cause"); // R5
    AST_WE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.we |-> $past(dready_i)) else $error("write without ready"); // R3
    AST_NO_ACK_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ack |=> !r_q.ack) else $error("double ack"); // R3
    AST_BYPASS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cfg_bypass_i) |=> (r_q.st == ST_IDLE)) else $error("left idle in bypass"); // R8
endmodule

// File: rtl/evt_readout_seq.sv
module evt_readout_seq #(
    parameter int DATA_W = 16,
    parameter int TMO_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_test_mode,
    input  logic              cfg_tmo_en,
    input  logic              cfg_bypass,
    input  logic              cfg_early_done,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              start_rd,
    input  logic              dready,
    input  logic [DATA_W-1:0] din,
    input  logic              last_pass,
    input  logic              ext_done,
    input  logic              tst_rd_strobe,
    input  logic              tst_wr_strobe,
    input  logic              val_in,
    input  logic              valack_in,
    output logic              renin,
    output logic              word_ack,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              eoe_n,
    output logic              tmo_flag
);
    logic start_rise;

    evrd_rise u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (start_rd),
        .rise_o (start_rise)
    );

    evrd_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_rise_i (start_rise),
        .dready_i     (dready),
        .din_i        (din),
        .lastpass_i   (last_pass),
        .ext_done_i   (ext_done),
        .tst_rd_i     (tst_rd_strobe),
        .tst_wr_i     (tst_wr_strobe),
        .cfg_test_i   (cfg_test_mode),
        .cfg_bypass_i (cfg_bypass),
        .cfg_early_i  (cfg_early_done),
        .renin_o      (renin),
        .ack_o        (word_ack),
        .we_o         (fifo_we),
        .data_o       (fifo_wdata),
        .eoe_n_o      (eoe_n)
    );

    evrd_wdog #(.TMO_W(TMO_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg_tmo_en),
        .limit_i  (tmo_limit),
        .val_i    (val_in),
        .valack_i (valack_in),
        .flag_o   (tmo_flag)
    );
endmodule

// File: tb/evt_readout_seq_bench.sv
module evt_readout_seq_bench;
    localparam int DW = 16;
    localparam int TW = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_test_mode = 0, cfg_tmo_en = 0, cfg_bypass = 0, cfg_early_done = 0;
    logic [TW-1:0] tmo_limit = '0;
    logic start_rd = 0, dready = 0, last_pass = 0, ext_done = 0;
    logic tst_rd_strobe = 0, tst_wr_strobe = 0, val_in = 0, valack_in = 0;
    logic [DW-1:0] din = '0;
    logic renin, word_ack, fifo_we, eoe_n, tmo_flag;
    logic [DW-1:0] fifo_wdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    evt_readout_seq #(.DATA_W(DW), .TMO_W(TW)) u_evt_readout_seq (
        .clk(clk), .rst_n(rst_n), .cfg_test_mode(cfg_test_mode), .cfg_tmo_en(cfg_tmo_en),
        .cfg_bypass(cfg_bypass), .cfg_early_done(cfg_early_done), .tmo_limit(tmo_limit),
        .start_rd(start_rd), .dready(dready), .din(din), .last_pass(last_pass),
        .ext_done(ext_done), .tst_rd_strobe(tst_rd_strobe), .tst_wr_strobe(tst_wr_strobe),
        .val_in(val_in), .valack_in(valack_in), .renin(renin), .word_ack(word_ack),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .eoe_n(eoe_n), .tmo_flag(tmo_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] rand_word();
        return DW'($urandom);
    endfunction

    task automatic run_event(input bit early, input bit tmode, input int nw);
        logic [DW-1:0] exp_w;
        cfg_early_done = early;
        cfg_test_mode  = tmode;
        start_rd = 1;
        step();
        chk("R2 renin after start edge", renin, 1);
        step();
        chk("R2 no repeat while start held", renin, 0);
        for (int w = 0; w < nw; w++) begin
            dready = 1;
            exp_w  = rand_word();
            din    = exp_w;
            step();
            chk("R3 word ack", word_ack, 1);
            chk("R3 fifo write", fifo_we, 1);
            chk("R3 fifo data", fifo_wdata, exp_w);
            if ($urandom % 2 == 1) begin
                step();
                chk("R3 held ready not rewritten", fifo_we, 0);
            end
            dready = 0;
            step();
        end
        if (!tmode && early) begin
            tst_wr_strobe = 1;
            step();
            tst_wr_strobe = 0;
            chk("R11 write strobe ignored outside test", eoe_n, 1);
        end
        if (tmode) tst_wr_strobe = 1;
        else       last_pass = 1;
        step();
        tst_wr_strobe = 0;
        last_pass = 0;
        if (early) begin
            chk("R5 eoe at last-pass", eoe_n, 0);
            step();
            chk("R7 eoe one cycle", eoe_n, 1);
        end else begin
            chk("R6 no eoe at last-pass", eoe_n, 1);
            dready = 1;
            step();
            chk("R4 ready ignored while waiting", word_ack, 0);
            chk("R4 no write while waiting", fifo_we, 0);
            dready = 0;
            step();
            chk("R6 still waiting", eoe_n, 1);
            ext_done = 1;
            step();
            ext_done = 0;
            chk("R6 eoe after ext_done", eoe_n, 0);
            step();
            chk("R7 eoe one cycle", eoe_n, 1);
        end
        start_rd = 0;
        ext_done = 1;
        step();
        ext_done = 0;
        step();
        chk("R6 ext_done ignored when idle", eoe_n, 1);
        cfg_test_mode = 0;
    endtask

    task automatic wd_expire(input int lim);
        cfg_tmo_en = 1;
        tmo_limit  = TW'(lim);
        val_in = 1;
        step();
        val_in = 0;
        for (int i = 1; i < lim; i++) step();
        chk("R9 quiet before limit", tmo_flag, 0);
        step();
        chk("R9 flag at limit", tmo_flag, 1);
        step();
        chk("R9 flag held", tmo_flag, 1);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) step();
        chk("R1 renin reset", renin, 0);
        chk("R1 ack reset", word_ack, 0);
        chk("R1 we reset", fifo_we, 0);
        chk("R1 eoe_n reset", eoe_n, 1);
        chk("R1 flag reset", tmo_flag, 0);
        rst_n = 1;
        step();

        dready = 1;
        step();
        chk("R4 ready ignored in idle", word_ack, 0);
        dready = 0;
        step();

        run_event(1'b1, 1'b0, 3);
        run_event(1'b0, 1'b0, 2);
        run_event(1'b1, 1'b1, 1);
        for (int e = 0; e < 16; e++)
            run_event(1'($urandom), 1'($urandom), 1 + int'($urandom % 6));

        cfg_bypass = 1;
        start_rd = 1;
        step();
        chk("R8 no renin in bypass", renin, 0);
        dready = 1;
        step();
        chk("R8 no ack in bypass", word_ack, 0);
        dready = 0;
        start_rd = 0;
        cfg_bypass = 0;
        step();

        tst_rd_strobe = 1;
        step();
        chk("R11 read strobe ignored outside test", renin, 0);
        cfg_test_mode = 1;
        step();
        tst_rd_strobe = 0;
        chk("R11 read strobe gives renin", renin, 1);
        step();
        chk("R11 renin one cycle", renin, 0);
        cfg_test_mode = 0;

        wd_expire(2);
        cfg_tmo_en = 0;
        step();
        chk("R10 flag dropped with enable", tmo_flag, 0);
        for (int k = 0; k < 5; k++) begin
            wd_expire(2 + int'($urandom % 30));
            val_in = 1;
            step();
            val_in = 0;
            chk("R9 flag cleared on rearm", tmo_flag, 0);
            cfg_tmo_en = 0;
            step();
        end
        for (int k = 0; k < 5; k++) begin
            int lim;
            int wait_n;
            lim = 3 + int'($urandom % 20);
            wait_n = int'($urandom % (lim - 1));
            cfg_tmo_en = 1;
            tmo_limit = TW'(lim);
            val_in = 1;
            step();
            val_in = 0;
            for (int i = 0; i < wait_n; i++) step();
            valack_in = 1;
            step();
            valack_in = 0;
            for (int i = 0; i < lim + 2; i++) step();
            chk("R10 valack prevents flag", tmo_flag, 0);
        end
        cfg_tmo_en = 0;
        val_in = 1;
        step();
        val_in = 0;
        for (int i = 0; i < 10; i++) step();
        chk("R10 disabled watchdog stays quiet", tmo_flag, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule